// File: doc/BRIEF.md
# Page Write Buffer Programming Controller

This block sits behind the serial front end of a byte-addressable nonvolatile memory. It gathers the data bytes of one write command into a page-sized staging buffer and then copies them into the storage array during a timed programming window. The front end gives it a start address when the address phase of a write completes. It then gives one strobe per received data byte, and one pulse when chip select returns high. That pulse carries a flag saying whether the serial bit counter was on a byte boundary. An abort input drops whatever has been gathered.

The page holds 64 bytes. Incoming bytes move a pointer through the low six address bits only, so a long burst wraps back to the start of the same page and replaces bytes gathered earlier. A correctly placed chip-select rise with at least one byte gathered starts programming. Busy is then held for a parameterised number of clock cycles. In the first 64 of those cycles the buffer is swept one entry per cycle. Each entry that was loaded is written, provided the external protection qualifier allows that address. When the window ends, a one-cycle pulse tells the front end to clear its write-enable latch. The storage array is an internal register array with a read port for observation.

Top module: `pgbuf_prog_top`

## Requirements
- R1: After reset, busy, the array write enable and the latch-clear pulse are all 0.
- R2: Each accepted byte is stored at the current pointer. The pointer then advances by one in the low six address bits, and the upper address bits of the start address stay fixed.
- R3: A byte arriving after pointer offset 63 goes to offset 0 of the same page, and a later byte at an offset replaces the earlier byte at that offset.
- R4: Programming starts only on a chip-select rise with the byte-boundary flag at 1 and at least one byte gathered. A rise with the flag at 0 starts nothing and discards the gathered bytes.
- R5: Busy rises in the cycle after the starting chip-select rise and stays 1 for exactly PROG_CYCLES cycles, with PROG_CYCLES at least 64.
- R6: The latch-clear output is 1 for exactly one cycle, the first cycle in which busy is 0 again after a programming window.
- R7: While busy is 1, address loads, data strobes, chip-select rises and abort have no effect, and the window runs to its full length.
- R8: A byte whose array address has the allow qualifier at 0 during the sweep is not written, and that array location keeps its old value.
- R9: Only buffer offsets that received a byte in the current command are written; all other locations in the page keep their values.
- R10: Abort while idle discards the gathered bytes, so a following byte-aligned chip-select rise starts no programming.
- R11: The array write enable is 1 only while busy is 1, for at most 64 cycles per window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_load | input | 1 | Load start address and clear the buffer |
| start_addr | input | ADDR_W | Start byte address of the write command |
| byte_stb | input | 1 | One received data byte is present |
| byte_in | input | DATA_W | Received data byte |
| cs_rise | input | 1 | Chip select returned high |
| bit_aligned | input | 1 | Serial bit counter was on a byte boundary at the rise |
| abort | input | 1 | Discard gathered bytes |
| arr_allow | input | 1 | Protection qualifier for the current arr_addr |
| busy | output | 1 | Programming window active |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| wel_clr | output | 1 | One-cycle pulse clearing the write-enable latch |
| rd_addr | input | ADDR_W | Observation read address |
| rd_data | output | DATA_W | Array content at rd_addr |

## Verification
The hardest case to reach from the ports is traffic that arrives while the window is running. This includes a new address load, a byte strobe, an abort and a fresh aligned chip-select rise. None of them may reach the buffer, the sweep or the timer. The stimulus commits a one-byte write and then drives each of these inputs during the busy cycles. It then checks three things: the window length is unchanged, only the first byte reached the array, and no second window follows. Misaligned rises and aborts are also checked indirectly. A later aligned rise must start no programming, which shows that the buffer was emptied.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  // Action applied to the staging buffer in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_STORE = 2'd3
  } col_act_e;

endpackage

// File: rtl/pgbuf_collect.sv
module pgbuf_collect
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        busy_i,
  input  logic                        fin_i,
  input  logic                        load_i,
  input  logic [ADDR_W-1:0]           start_addr_i,
  input  logic                        byte_vld_i,
  input  logic [DATA_W-1:0]           byte_i,
  input  logic                        cs_rise_i,
  input  logic                        aligned_i,
  input  logic                        abort_i,
  input  logic [PAGE_BITS-1:0]        sweep_idx_i,
  output logic                        commit_o,
  output logic [ADDR_W-PAGE_BITS-1:0] page_o,
  output logic [DATA_W-1:0]           ent_data_o,
  output logic                        ent_vld_o
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int HI_W      = ADDR_W - PAGE_BITS;

  logic [HI_W-1:0]      page_q, page_d;
  logic [PAGE_BITS-1:0] ptr_q, ptr_d;
  logic [PAGE_SIZE-1:0] mask_q, mask_d;
  logic [DATA_W-1:0]    buf_q [PAGE_SIZE];
  col_act_e             act;

  // Action selection: a running window freezes everything except the final clear
  always_comb begin
    act = ACT_HOLD;
    if (busy_i) begin
      if (fin_i) act = ACT_CLEAR;
    end else if (abort_i || (cs_rise_i && !aligned_i)) begin
      act = ACT_CLEAR;
    end else if (cs_rise_i) begin
      act = ACT_HOLD;
    end else if (load_i) begin
      act = ACT_LOAD;
    end else if (byte_vld_i) begin
      act = ACT_STORE;
    end
  end

  always_comb begin
    page_d = page_q;
    ptr_d  = ptr_q;
    mask_d = mask_q;
    unique case (act)
      ACT_CLEAR: mask_d = '0;
      ACT_LOAD: begin
        page_d = start_addr_i[ADDR_W-1:PAGE_BITS];
        ptr_d  = start_addr_i[PAGE_BITS-1:0];
        mask_d = '0;
      end
      ACT_STORE: begin
        mask_d[ptr_q] = 1'b1;
        ptr_d         = ptr_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
    end else begin
      page_q <= page_d;
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
    end
  end

  // Data storage carries no reset; entries are qualified by mask_q
  always_ff @(posedge clk) begin
    if (act == ACT_STORE) begin
      buf_q[ptr_q] <= byte_i;
    end
  end

  assign commit_o   = !busy_i && cs_rise_i && aligned_i && (|mask_q);
  assign page_o     = page_q;
  assign ent_data_o = buf_q[sweep_idx_i];
  assign ent_vld_o  = mask_q[sweep_idx_i];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_i && !abort_i && !cs_rise_i && !load_i && byte_vld_i)
      |=> (ptr_q == $past(ptr_q) + 1'b1) && $stable(page_q)); // R2

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_i && !fin_i) |=> $stable(mask_q) && $stable(ptr_q) && $stable(page_q)); // R7

  AST_MISALIGN_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_i && cs_rise_i && !aligned_i) |=> (mask_q == '0)); // R4

  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_i && abort_i) |=> (mask_q == '0)); // R10

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int CYCLES    = 100,
  parameter int PAGE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic                 fin_o,
  output logic                 done_o,
  output logic                 sweep_o,
  output logic [PAGE_BITS-1:0] idx_o
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic                 busy_q, busy_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 sweep_q, sweep_d;
  logic [PAGE_BITS-1:0] idx_q, idx_d;
  logic                 done_q, done_d;
  logic                 last;

  assign last = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    sweep_d = sweep_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    if (start_i && !busy_q) begin
      busy_d  = 1'b1;
      cnt_d   = CNT_W'(CYCLES);
      sweep_d = 1'b1;
      idx_d   = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
      if (sweep_q) begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '1) sweep_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sweep_q <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      sweep_q <= sweep_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = busy_q;
  assign fin_o   = last;
  assign done_o  = done_q;
  assign sweep_o = sweep_q;
  assign idx_o   = idx_q;

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && cnt_q > CNT_W'(1)) |=> busy_q); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_SWEEP_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    sweep_o |-> busy_o); // R11

endmodule

// File: rtl/pgbuf_array.sv
module pgbuf_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/pgbuf_prog_top.sv
module pgbuf_prog_top #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 6,
  parameter int PROG_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              cs_rise,
  input  logic              bit_aligned,
  input  logic              abort,
  input  logic              arr_allow,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              wel_clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int HI_W      = ADDR_W - PAGE_BITS;
  // The sweep needs one cycle per page entry inside the window
  localparam int WIN_CYCLES = (PROG_CYCLES < PAGE_SIZE) ? PAGE_SIZE : PROG_CYCLES;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic                 commit;
  logic                 fin;
  logic                 sweep;
  logic [PAGE_BITS-1:0] idx;
  logic [HI_W-1:0]      page;
  logic [DATA_W-1:0]    ent_data;
  logic                 ent_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  pgbuf_collect #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_BITS(PAGE_BITS)
  ) u_collect (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .busy_i      (busy),
    .fin_i       (fin),
    .load_i      (start_load),
    .start_addr_i(start_addr),
    .byte_vld_i  (byte_stb),
    .byte_i      (byte_in),
    .cs_rise_i   (cs_rise),
    .aligned_i   (bit_aligned),
    .abort_i     (abort),
    .sweep_idx_i (idx),
    .commit_o    (commit),
    .page_o      (page),
    .ent_data_o  (ent_data),
    .ent_vld_o   (ent_vld)
  );

  pgbuf_timer #(
    .CYCLES   (WIN_CYCLES),
    .PAGE_BITS(PAGE_BITS)
  ) u_timer (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .start_i(commit),
    .busy_o (busy),
    .fin_o  (fin),
    .done_o (wel_clr),
    .sweep_o(sweep),
    .idx_o  (idx)
  );

  assign arr_addr  = {page, idx};
  assign arr_wdata = ent_data;
  assign arr_we    = sweep && ent_vld && arr_allow;

  pgbuf_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk    (clk),
    .we_i   (arr_we),
    .waddr_i(arr_addr),
    .wdata_i(arr_wdata),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    arr_we |-> busy); // R11

  AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit |=> busy); // R4

  AST_NO_MISALIGNED_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && cs_rise && !bit_aligned) |=> !busy); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !commit) |=> !busy); // R5

endmodule

// File: tb/pgbuf_prog_top_tb_top.sv
`timescale 1ns/1ps
module pgbuf_prog_top_tb_top;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int PROG   = 100;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_load, byte_stb, cs_rise, bit_aligned, abort, arr_allow;
  logic [ADDR_W-1:0] start_addr, rd_addr, arr_addr;
  logic [DATA_W-1:0] byte_in, arr_wdata, rd_data;
  logic              busy, arr_we, wel_clr;
  logic              prot_on;

  int n_chk = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int run_len = 0;
  int last_len = 0;
  bit done_flag = 0;

  logic [7:0] emem [0:1023];
  bit         eknw [0:1023];
  logic [7:0] pbuf [0:63];
  bit         pmsk [0:63];
  int         ppage, pptr;

  always #10 clk = ~clk;

  pgbuf_prog_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(6), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_load(start_load), .start_addr(start_addr),
    .byte_stb(byte_stb), .byte_in(byte_in), .cs_rise(cs_rise), .bit_aligned(bit_aligned),
    .abort(abort), .arr_allow(arr_allow), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .wel_clr(wel_clr), .rd_addr(rd_addr), .rd_data(rd_data));

  // Protection model: upper half of every page blocked when prot_on
  always_comb arr_allow = !(prot_on && arr_addr[5]);

  always @(posedge clk) begin
    if (arr_we) we_cnt <= we_cnt + 1;
    if (busy) run_len <= run_len + 1;
    else if (run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed * 7 + i * 13 + 1);
  endfunction

  task automatic do_load(int a);
    @(negedge clk); start_load = 1; start_addr = ADDR_W'(a);
    @(negedge clk); start_load = 0;
    ppage = a / 64; pptr = a % 64;
    for (int j = 0; j < 64; j++) pmsk[j] = 0;
  endtask

  task automatic do_byte(logic [7:0] d);
    @(negedge clk); byte_stb = 1; byte_in = d;
    @(negedge clk); byte_stb = 0;
    if (!busy) begin
      pbuf[pptr] = d; pmsk[pptr] = 1; pptr = (pptr + 1) % 64;
    end
  endtask

  task automatic do_cs(bit al);
    @(negedge clk); cs_rise = 1; bit_aligned = al;
    @(negedge clk); cs_rise = 0; bit_aligned = 1;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
  endtask

  task automatic page_send(int a, int n, int seed);
    do_load(a);
    for (int i = 0; i < n; i++) do_byte(pat(seed, i));
  endtask

  // Wait for the window to end and check its length and the latch-clear pulse
  task automatic finish_window(string rq);
    int exp_we;
    while (busy) @(negedge clk);
    chk({rq, "/R6 wel_clr in first idle cycle"}, int'(wel_clr), 1);
    @(negedge clk);
    chk({rq, "/R6 wel_clr single cycle"}, int'(wel_clr), 0);
    chk({rq, "/R5 busy length"}, last_len, PROG);
    exp_we = 0;
    for (int j = 0; j < 64; j++) begin
      if (pmsk[j] && !(prot_on && j >= 32)) begin
        emem[ppage * 64 + j] = pbuf[j]; eknw[ppage * 64 + j] = 1; exp_we++;
      end
      pmsk[j] = 0;
    end
    chk({rq, "/R11 write count"}, we_cnt, exp_we);
  endtask

  task automatic commit(string rq);
    we_cnt = 0;
    do_cs(1);
    chk({rq, "/R4 busy after aligned rise"}, int'(busy), 1);
    finish_window(rq);
  endtask

  task automatic check_page(string rq, int pg);
    for (int j = 0; j < 64; j++) begin
      if (eknw[pg * 64 + j]) begin
        @(negedge clk); rd_addr = ADDR_W'(pg * 64 + j); #1;
        chk(rq, int'(rd_data), int'(emem[pg * 64 + j]));
      end
    end
  endtask

  task automatic check_no_start(string rq);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk(rq, int'(busy), 0);
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 arr_we", int'(arr_we), 0);
    chk("R1 wel_clr", int'(wel_clr), 0);
  endtask

  task automatic t_full_page();
    page_send(2 * 64, 64, 1);
    commit("R2 full page");
    check_page("R2 full page data", 2);
  endtask

  task automatic t_partial();
    page_send(2 * 64 + 60, 3, 2);
    commit("R9 partial");
    check_page("R9 untouched bytes kept", 2);
  endtask

  task automatic t_wrap();
    page_send(3 * 64 + 62, 5, 3);
    commit("R3 wrap");
    check_page("R3 wrap stays in page", 3);
    @(negedge clk); rd_addr = ADDR_W'(3 * 64); #1;
    chk("R3 offset0 got third byte", int'(rd_data), int'(pat(3, 2)));
    page_send(4 * 64, 66, 4);
    commit("R3 overwrite");
    @(negedge clk); rd_addr = ADDR_W'(4 * 64 + 1); #1;
    chk("R3 later byte replaces earlier", int'(rd_data), int'(pat(4, 65)));
    check_page("R3 overwrite page", 4);
  endtask

  task automatic t_misaligned();
    page_send(2 * 64, 1, 5);
    do_cs(0);
    check_no_start("R4 misaligned rise no start");
    do_cs(1);
    check_no_start("R4 buffer discarded");
    for (int j = 0; j < 64; j++) pmsk[j] = 0;
    check_page("R4 array unchanged", 2);
  endtask

  task automatic t_abort();
    page_send(2 * 64 + 10, 2, 6);
    do_abort();
    do_cs(1);
    check_no_start("R10 abort discards");
    for (int j = 0; j < 64; j++) pmsk[j] = 0;
    check_page("R10 array unchanged", 2);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] keep134;
    keep134 = emem[134];
    page_send(2 * 64 + 5, 1, 7);
    we_cnt = 0;
    do_cs(1);
    chk("R7 window started", int'(busy), 1);
    @(negedge clk); start_load = 1; start_addr = ADDR_W'(2 * 64 + 6);
    @(negedge clk); start_load = 0; byte_stb = 1; byte_in = 8'h99;
    @(negedge clk); byte_stb = 0; abort = 1;
    @(negedge clk); abort = 0; cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    chk("R7 still busy", int'(busy), 1);
    finish_window("R7 window unaffected");
    check_no_start("R7 no second window");
    @(negedge clk); rd_addr = ADDR_W'(134); #1;
    chk("R7 ignored byte not written", int'(rd_data), int'(keep134));
    check_page("R7 page content", 2);
  endtask

  task automatic t_protect();
    page_send(6 * 64, 64, 8);
    commit("R8 prefill");
    prot_on = 1;
    page_send(6 * 64, 64, 9);
    commit("R8 protected commit");
    check_page("R8 blocked half kept, open half new", 6);
    prot_on = 0;
  endtask

  initial begin
    rst_n = 0; start_load = 0; start_addr = '0; byte_stb = 0; byte_in = '0;
    cs_rise = 0; bit_aligned = 1; abort = 0; rd_addr = '0; prot_on = 0;
    for (int j = 0; j < 1024; j++) begin emem[j] = '0; eknw[j] = 0; end
    for (int j = 0; j < 64; j++) begin pbuf[j] = '0; pmsk[j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_page();
    t_partial();
    t_wrap();
    t_misaligned();
    t_abort();
    t_busy_ignore();
    t_protect();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule